// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup stage of a first-level data cache that starts selecting a set before address translation has finished. The core presents a virtual address. Every bit that picks the set and the byte inside the line lies below the page boundary, so those bits are the same before and after translation. The set is therefore latched in the request cycle. In a later cycle the translation unit supplies the physical page number with a valid flag. The stored tags of the latched set are compared against that page number, and the block answers with hit or miss and the addressed word.

On a miss the block asks the next memory level for the whole aligned line. It writes the returned line and its tag into a way chosen by a round-robin pointer kept for each set, then answers the access. Stores that hit merge their enabled bytes into the line in place. Stores that miss first allocate the line and then merge. Associativity, line size, set count and access word size are parameters. A geometry in which index and offset bits together exceed the page-offset width is rejected at elaboration. If the two fields use fewer bits than the page offset, the remaining page-offset bits join the page number in the tag.

A controller with three states sequences each access. IDLE accepts a request (transition ACCEPT to LOOKUP). LOOKUP waits while the page number is not valid (transition STALL), returns to IDLE on a hit (transition HIT), or moves to FILL on a miss (transition MISS). FILL holds its request to the next level (transition WAIT) until the line arrives, then answers and returns to IDLE (transition REFILL).

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid` and `fill_req` are 0; the first access to any set is a miss.
- R2: The byte offset is page-offset bits [OFF_W-1:0] and the set index is bits [OFF_W+IDX_W-1:OFF_W], both taken from the virtual address; bits above the page offset have no effect on set selection, and the tag is the full page number. With 4-byte lines, 16 sets, 6-bit page offset and 6-bit page number, physical address 0x354 selects set 5, tag 0x0D, byte 0 (line bits [7:0]).
- R3: A request is accepted in a cycle with `req_valid` high in IDLE (`req_ready` high). In the first later cycle with `ppn_valid` high, a hit raises `resp_valid` and `resp_hit` in that same cycle, with `resp_rdata` holding the word at the offset (byte k of a line is `line[8k+7:8k]`). `req_ready` returns the cycle after.
- R4: While `ppn_valid` is low after a request is accepted, `resp_valid` and `fill_req` stay 0 and the lookup waits.
- R5: On a miss (no valid way with a matching tag) no response is given in the compare cycle. From the next cycle `fill_req` is held with `fill_addr` = {page number, index, zero offset} until `fill_valid`. In the `fill_valid` cycle `resp_valid` is 1, `resp_hit` is 0, and `resp_rdata` is taken from `fill_data`.
- R6: Each set has a victim pointer that starts at way 0. A refill writes the pointed way and advances that pointer by one, wrapping after the last way, so refills of one set evict its ways in turn.
- R7: A store that hits replaces exactly the bytes whose bit in `req_be` is 1 (bit k covers byte k of the word). The response carries the merged word, and a store with all enables 0 leaves the line unchanged.
- R8: A store that misses allocates the line, merges its enabled bytes into the returned line before it is written, and returns the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_wdata | input | 8*WORD_BYTES | Store data |
| req_be | input | WORD_BYTES | Store byte enables |
| req_ready | output | 1 | Block is idle and accepts a request |
| ppn_valid | input | 1 | Translated page number is valid |
| ppn | input | PPN_W | Physical page number from the translation unit |
| resp_valid | output | 1 | Access answered this cycle |
| resp_hit | output | 1 | Answer came from a hit |
| resp_rdata | output | 8*WORD_BYTES | Word at the addressed offset (merged for stores) |
| fill_req | output | 1 | Line request to the next level |
| fill_addr | output | PPN_W+PAGE_OFF_W | Line-aligned physical address of the request |
| fill_valid | input | 1 | Requested line is on `fill_data` |
| fill_data | input | 8*LINE_BYTES | Returned line, byte 0 in the low bits |

## Verification
The assertions assume that `ppn_valid` is raised only while an accepted access waits for its page number, and that `fill_valid` comes only while `fill_req` is high. They also assume that the page number stays steady in the compare cycle. The stimulus keeps to these limits because one task drives each access through its whole sequence. That task raises the page number only after a chosen number of stall cycles and answers a fill only after observing the request. Random loads and stores mix a small pool of page numbers over all sets, so replacements, repeated hits and write merges all occur. Directed cases cover the worked address, stalls, rotation through every way of one set, and stores with enables both on and off.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } vipt_state_e;
endpackage

// File: rtl/vipt_tag_array.sv
`timescale 1ns/1ps
// Tag and valid storage; parallel compare of all ways of one set.
module vipt_tag_array #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int TAG_W = 40,
    parameter int IDX_W = 6,
    parameter int WAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_i,
    input  logic [TAG_W-1:0] cmp_tag_i,
    output logic [WAYS-1:0]  hit_vec_o,
    input  logic             we_i,
    input  logic [WAY_W-1:0] wr_way_i,
    input  logic [TAG_W-1:0] wr_tag_i
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (we_i) begin
            valid_q[set_i][wr_way_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) tag_q[set_i][wr_way_i] <= wr_tag_i;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_q[set_i][w] && (tag_q[set_i][w] == cmp_tag_i);
    end
endmodule

// File: rtl/vipt_data_array.sv
`timescale 1ns/1ps
// Line storage: one read/write port addressed by set and way.
module vipt_data_array #(
    parameter int SETS   = 64,
    parameter int WAYS   = 8,
    parameter int LINE_W = 512,
    parameter int IDX_W  = 6,
    parameter int WAY_W  = 3
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  set_i,
    input  logic [WAY_W-1:0]  way_i,
    output logic [LINE_W-1:0] rd_line_o,
    input  logic              we_i,
    input  logic [LINE_W-1:0] wr_line_i
);
    logic [LINE_W-1:0] mem_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[set_i][way_i] <= wr_line_i;
    end

    assign rd_line_o = mem_q[set_i][way_i];
endmodule

// File: rtl/vipt_victim_rr.sv
`timescale 1ns/1ps
// Per-set round-robin victim pointer.
module vipt_victim_rr #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int IDX_W = 6,
    parameter int WAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_i,
    input  logic             adv_i,
    output logic [WAY_W-1:0] victim_o
);
    logic [WAY_W-1:0] ptr_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv_i) begin
            ptr_q[set_i] <= (ptr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[set_i] + 1'b1;
        end
    end

    assign victim_o = ptr_q[set_i];
endmodule

// File: rtl/vipt_cache.sv
`timescale 1ns/1ps
// L1 data cache lookup: set chosen from virtual page-offset bits,
// tag compared against the physical page number when it arrives.
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PPN_W      = 40,
    parameter int PAGE_OFF_W = 12,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 8,
    parameter int WORD_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [WORD_BYTES*8-1:0]       req_wdata,
    input  logic [WORD_BYTES-1:0]         req_be,
    output logic                          req_ready,
    input  logic                          ppn_valid,
    input  logic [PPN_W-1:0]              ppn,
    output logic                          resp_valid,
    output logic                          resp_hit,
    output logic [WORD_BYTES*8-1:0]       resp_rdata,
    output logic                          fill_req,
    output logic [PPN_W+PAGE_OFF_W-1:0]   fill_addr,
    input  logic                          fill_valid,
    input  logic [LINE_BYTES*8-1:0]       fill_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int PA_W   = PPN_W + PAGE_OFF_W;
    localparam int GAP_W  = PAGE_OFF_W - OFF_W - IDX_W;
    localparam int TAG_W  = PPN_W + ((GAP_W > 0) ? GAP_W : 0);

    // Geometry checks: index and offset must sit inside the page offset.
    if (OFF_W + IDX_W > PAGE_OFF_W) begin : g_bad_geometry
        $error("vipt_cache: index plus offset bits exceed the page offset");
    end
    if (WORD_BYTES > LINE_BYTES) begin : g_bad_word
        $error("vipt_cache: access word wider than a line");
    end

    vipt_state_e state_q, state_d;

    logic [PAGE_OFF_W-1:0] pgoff_q;
    logic                  wr_q;
    logic [WORD_W-1:0]     wdata_q;
    logic [WORD_BYTES-1:0] be_q;
    logic [PPN_W-1:0]      ppn_q;
    logic [WAY_W-1:0]      victim_q;

    logic [IDX_W-1:0]  set_idx;
    logic [OFF_W-1:0]  byte_off;
    logic [TAG_W-1:0]  look_tag, fill_tag;
    logic [WAYS-1:0]   hit_vec;
    logic              lookup_hit;
    logic [WAY_W-1:0]  hit_way, data_way, rr_victim;
    logic [LINE_W-1:0] rd_line, base_line, merged_line;
    logic              data_we, tag_we, rr_adv;
    int                byte_base;
    logic              unused_vpn;

    assign unused_vpn = ^req_vaddr[VA_W-1:PAGE_OFF_W];
    assign set_idx    = pgoff_q[OFF_W +: IDX_W];
    assign byte_off   = pgoff_q[OFF_W-1:0];
    assign byte_base  = (int'(byte_off) / WORD_BYTES) * WORD_BYTES;

    // Tag = page number, plus any page-offset bits left above the index.
    if (GAP_W > 0) begin : g_gap
        assign look_tag = {ppn,   pgoff_q[PAGE_OFF_W-1 -: GAP_W]};
        assign fill_tag = {ppn_q, pgoff_q[PAGE_OFF_W-1 -: GAP_W]};
    end else begin : g_nogap
        assign look_tag = ppn;
        assign fill_tag = ppn_q;
    end

    vipt_tag_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .set_i(set_idx), .cmp_tag_i(look_tag),
        .hit_vec_o(hit_vec), .we_i(tag_we), .wr_way_i(victim_q), .wr_tag_i(fill_tag)
    );

    vipt_data_array #(
        .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_data (
        .clk(clk), .set_i(set_idx), .way_i(data_way), .rd_line_o(rd_line),
        .we_i(data_we), .wr_line_i(merged_line)
    );

    vipt_victim_rr #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_rr (
        .clk(clk), .rst_n(rst_n), .set_i(set_idx), .adv_i(rr_adv), .victim_o(rr_victim)
    );

    assign lookup_hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Store merge over either the hit line or the returned line.
    always_comb begin
        base_line   = (state_q == ST_FILL) ? fill_data : rd_line;
        merged_line = base_line;
        if (wr_q) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                if (be_q[b]) merged_line[(byte_base + b)*8 +: 8] = wdata_q[b*8 +: 8];
            end
        end
    end

    assign resp_rdata = merged_line[byte_base*8 +: WORD_W];
    assign fill_addr  = {ppn_q, pgoff_q[PAGE_OFF_W-1:OFF_W], {OFF_W{1'b0}}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: if (ppn_valid) state_d = lookup_hit ? ST_IDLE : ST_FILL;
            ST_FILL:   if (fill_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        fill_req   = 1'b0;
        data_we    = 1'b0;
        tag_we     = 1'b0;
        rr_adv     = 1'b0;
        data_way   = hit_way;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOOKUP: begin
                resp_valid = ppn_valid && lookup_hit;
                resp_hit   = ppn_valid && lookup_hit;
                data_we    = ppn_valid && lookup_hit && wr_q;
            end
            ST_FILL: begin
                fill_req   = 1'b1;
                resp_valid = fill_valid;
                data_we    = fill_valid;
                tag_we     = fill_valid;
                rr_adv     = fill_valid;
                data_way   = victim_q;
            end
            default: ;
        endcase
    end

    // Request and miss context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgoff_q  <= '0;
            wr_q     <= 1'b0;
            wdata_q  <= '0;
            be_q     <= '0;
            ppn_q    <= '0;
            victim_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                pgoff_q <= req_vaddr[PAGE_OFF_W-1:0];
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (state_q == ST_LOOKUP && ppn_valid && !lookup_hit) begin
                ppn_q    <= ppn;
                victim_q <= rr_victim;
            end
        end
    end
endmodule

// File: rtl/vipt_cache_chk.sv
`timescale 1ns/1ps
module vipt_cache_chk #(
    parameter int WAYS  = 8,
    parameter int PA_W  = 52,
    parameter int OFF_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            ppn_valid,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic            fill_req,
    input logic            fill_valid,
    input logic [PA_W-1:0] fill_addr,
    input logic [WAYS-1:0] hit_vec
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> !req_ready); // R3
    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n) resp_valid && resp_hit |-> !fill_req); // R3
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !ppn_valid && !fill_valid |-> !resp_valid); // R4
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) fill_req && !fill_valid |=> fill_req && $stable(fill_addr)); // R5
    AST_FILL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) fill_req |-> fill_addr[OFF_W-1:0] == '0); // R5
    AST_MISS_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n) resp_valid && !resp_hit |-> fill_valid); // R5
    AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R6
endmodule

bind vipt_cache vipt_cache_chk #(.WAYS(WAYS), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .ppn_valid(ppn_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .fill_req(fill_req), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .hit_vec(hit_vec)
);

// File: tb/sim_vipt_cache.sv
`timescale 1ns/1ps
module sim_vipt_cache;
    localparam int VA_W = 14, PPN_W = 6, PGO = 6, LB = 4, NS = 16, NW = 4, WB = 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic [7:0]  req_wdata = '0;
    logic [0:0]  req_be = '0;
    logic        req_ready;
    logic        ppn_valid = 1'b0;
    logic [5:0]  ppn = '0;
    logic        resp_valid, resp_hit;
    logic [7:0]  resp_rdata;
    logic        fill_req;
    logic [11:0] fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    logic        m_valid [NS][NW];
    logic [5:0]  m_tag   [NS][NW];
    logic [31:0] m_data  [NS][NW];
    int          m_rr    [NS];

    always #2.5 clk = ~clk;

    vipt_cache #(.VA_W(VA_W), .PPN_W(PPN_W), .PAGE_OFF_W(PGO), .LINE_BYTES(LB),
                 .SETS(NS), .WAYS(NW), .WORD_BYTES(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .ppn_valid(ppn_valid), .ppn(ppn), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_rdata(resp_rdata), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] mem_line(input logic [11:0] a);
        return ({20'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic access(input logic [13:0] va, input logic [5:0] p, input bit wr,
                          input logic [7:0] wd, input bit be, input int stall,
                          input int lat, input string tag);
        int idx = int'(va[5:2]);
        int off = int'(va[1:0]);
        bit hit = 1'b0;
        int hw = 0;
        logic [31:0] line;
        logic [7:0] exp_b;
        logic [11:0] la;
        for (int w = 0; w < NW; w++)
            if (m_valid[idx][w] && m_tag[idx][w] == p) begin hit = 1'b1; hw = w; end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd; req_be = be;
        #1 chk(req_ready == 1'b1, {"R3 ready ", tag}, 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int s = 0; s < stall; s++) begin
            #1 chk(!resp_valid && !fill_req, {"R4 stall quiet ", tag},
                   64'({resp_valid, fill_req}), 64'd0);
            @(negedge clk);
        end
        ppn_valid = 1'b1; ppn = p;
        #1;
        if (hit) begin
            line = m_data[idx][hw];
            if (wr && be) line[off*8 +: 8] = wd;
            exp_b = line[off*8 +: 8];
            m_data[idx][hw] = line;
            chk(resp_valid && resp_hit && resp_rdata == exp_b, {"R3 hit response ", tag},
                64'({resp_valid, resp_hit, resp_rdata}), 64'({2'b11, exp_b}));
        end else begin
            chk(!resp_valid && !fill_req, {"R5 no answer in compare cycle ", tag},
                64'({resp_valid, fill_req}), 64'd0);
        end
        @(negedge clk);
        ppn_valid = 1'b0;
        if (!hit) begin
            la = {p, va[5:2], 2'b00};
            for (int c = 0; c <= lat; c++) begin
                #1 chk(fill_req && fill_addr == la && !resp_valid, {"R5 fill request ", tag},
                       64'({fill_req, resp_valid, fill_addr}), 64'({2'b10, la}));
                if (c < lat) @(negedge clk);
            end
            line = mem_line(la);
            fill_data = line;
            fill_valid = 1'b1;
            if (wr && be) line[off*8 +: 8] = wd;
            exp_b = line[off*8 +: 8];
            #1 chk(resp_valid && !resp_hit && resp_rdata == exp_b, {"R5 refill response ", tag},
                   64'({resp_valid, resp_hit, resp_rdata}), 64'({2'b10, exp_b}));
            hw = m_rr[idx];
            m_valid[idx][hw] = 1'b1;
            m_tag[idx][hw] = p;
            m_data[idx][hw] = line;
            m_rr[idx] = (hw + 1) % NW;
            @(negedge clk);
            fill_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R3 watchdog expired act=%0d exp=%0d", 200000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < NS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < NW; w++) begin
                m_valid[s][w] = 1'b0; m_tag[s][w] = '0; m_data[s][w] = '0;
            end
        end
        repeat (4) @(negedge clk);
        #1 chk(req_ready && !resp_valid && !fill_req, "R1 outputs in reset",
               64'({req_ready, resp_valid, fill_req}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(req_ready && !resp_valid && !fill_req, "R1 outputs after reset",
               64'({req_ready, resp_valid, fill_req}), 64'b100);

        // R2: worked address 0x354 -> set 5, tag 0x0D, byte 0; R1 first access misses
        access({8'hC3, 6'h14}, 6'h0D, 1'b0, 8'h00, 1'b0, 0, 1, "R2 R1 cold miss");
        access({8'h12, 6'h14}, 6'h0D, 1'b0, 8'h00, 1'b0, 0, 0, "R2 other VPN hits");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_vaddr = {8'h77, 6'h14}; req_be = '0;
        @(negedge clk);
        req_valid = 1'b0; ppn_valid = 1'b1; ppn = 6'h0D;
        #1 chk(resp_hit && resp_rdata == mem_line(12'h354)[7:0], "R2 byte B0 of line 5",
               64'(resp_rdata), 64'(mem_line(12'h354)[7:0]));
        @(negedge clk);
        ppn_valid = 1'b0;

        // R4: stall before page number
        access({8'h01, 6'h15}, 6'h0D, 1'b0, 8'h00, 1'b0, 3, 0, "R4 stalled hit");
        access({8'h02, 6'h24}, 6'h09, 1'b0, 8'h00, 1'b0, 4, 2, "R4 stalled miss");

        // R7: store hit with enable on, then off
        access({8'h03, 6'h15}, 6'h0D, 1'b1, 8'h5C, 1'b1, 0, 0, "R7 store hit");
        access({8'h04, 6'h15}, 6'h0D, 1'b0, 8'h00, 1'b0, 0, 0, "R7 read merged");
        access({8'h05, 6'h15}, 6'h0D, 1'b1, 8'hFF, 1'b0, 0, 0, "R7 store no enable");
        access({8'h06, 6'h15}, 6'h0D, 1'b0, 8'h00, 1'b0, 0, 0, "R7 unchanged");

        // R8: store miss allocates
        access({8'h07, 6'h17}, 6'h22, 1'b1, 8'h77, 1'b1, 1, 1, "R8 store miss");
        access({8'h08, 6'h17}, 6'h22, 1'b0, 8'h00, 1'b0, 0, 0, "R8 read allocated");

        // R6: five refills of set 9 rotate through all ways
        for (int k = 0; k < 5; k++)
            access({8'h20, 4'd9, 2'd2}, 6'(6'h30 + k), 1'b0, 8'h00, 1'b0, 0, 0, "R6 rotate");
        access({8'h21, 4'd9, 2'd1}, 6'h30, 1'b0, 8'h00, 1'b0, 0, 0, "R6 evicted way refilled");
        access({8'h22, 4'd9, 2'd3}, 6'h32, 1'b0, 8'h00, 1'b0, 0, 0, "R6 survivor hits");
        access({8'h23, 4'd9, 2'd0}, 6'h31, 1'b0, 8'h00, 1'b0, 0, 0, "R6 second eviction");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0] rp = 6'(6'h10 + $urandom_range(0, 5));
            logic [13:0] rva = 14'($urandom);
            access(rva, rp, ($urandom_range(0, 2) == 0), 8'($urandom),
                   ($urandom_range(0, 3) != 0), $urandom_range(0, 2),
                   $urandom_range(0, 3), "R3 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule